// File: doc/BRIEF.md
# Age-Indexed Operand Belt with Value Metadata

This block takes the place of a register file. Operands are not named by register number. They are named by age: every result an operation produces goes in at the front of a short fixed-length queue, and everything already stored moves one place back. The entry at the back is lost on each push. Any position can be read by its distance from the front.

Each stored value carries a small tag. The tag holds:
- the operand width,
- whether the value is a packed vector,
- a speculation state: normal, NaR (a deferred error that records which operation produced it) or None (a no-op marker).

There are no global condition flags. The tag travels with the value through the built-in functional units. Each functional unit performs either an add (scalar or lane-wise) or a pass-through.

A separate sink-check port models a non-speculable consumer, such as a store or a branch condition. When the value that reaches this port is a NaR, the block raises a fault that reports the identifier recorded in that NaR.

The block has one literal slot and `NALU` functional-unit slots. Together they can push several results in the same cycle. Results enter in a fixed slot order.

Top module: `temporal_belt`

## Requirements
- R1: While reset is active and right after it, every belt entry has state None (code 2), data 0, width code 0 and vector flag 0, and `fault_valid` is low.
- R2: A cycle with exactly one push places the new entry at position 0. Every older entry moves from position p to p+1. The entry at position DEPTH-1 is discarded.
- R3: With k pushes in one cycle, results are placed in slot order: the literal slot first, then functional unit 0, then unit 1, and so on. Only valid slots count. The first valid slot lands at position 0, and older entries move back by k. With no push the belt holds.
- R4: The read ports return, combinationally, the full entry at any position. The belt contents they reflect are those as of the last clock edge. Functional units read their sources from the belt as it stands before the current cycle's pushes.
- R5: The tag encoding is as follows. Width codes are 0=8, 1=16, 2=32 and 3=64 bits; data is 32 bits, so 64 acts as 32. State codes are 0=normal, 1=NaR and 2=None. A NaR entry's data field holds the identifier of the producer that first went bad.
- R6: A scalar ADD (op code 0) on two normal operands returns (A+B) truncated to A's width, with upper bits zero. The result takes A's width and vector flag and is normal.
- R7: A vector ADD (vector flag set on A) adds each lane of A's width on its own, with no carry between lanes. A width of 32 or 64 forms a single 32-bit lane.
- R8: PASS (op code 1) copies entry A unchanged, including its tag and any NaR identifier. Entry B is ignored.
- R9: An ADD with no None operand but at least one NaR operand produces a NaR. Its data is the identifier of A if A is NaR, otherwise that of B. The width and vector flag come from A. No fault is raised.
- R10: An ADD with any None operand produces None with data 0. None takes precedence over NaR.
- R11: With `chk_valid` high, if the entry at `chk_idx` is NaR, `fault_valid` is high after the next edge and `fault_id` equals that entry's low ID_W data bits. A normal or None entry raises no fault.
- R12: The literal slot pushes exactly the data, width, vector flag and state given on its inputs, so that injected NaR values keep their identifier.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset, released synchronously inside |
| lit_valid | input | 1 | Push the literal entry this cycle |
| lit_data | input | DATA_W | Literal data |
| lit_wid | input | 2 | Literal width code |
| lit_vec | input | 1 | Literal vector flag |
| lit_state | input | 2 | Literal speculation state |
| alu_valid | input | NALU | Per-unit issue; result pushed at the edge |
| alu_op | input | NALU | Per-unit op: 0 ADD, 1 PASS |
| alu_src_a | input | NALU*IDX_W | Per-unit position of operand A |
| alu_src_b | input | NALU*IDX_W | Per-unit position of operand B |
| rd_idx | input | NRD*IDX_W | Per-read-port position |
| rd_data | output | NRD*DATA_W | Data at the selected positions |
| rd_wid | output | NRD*2 | Width codes at the selected positions |
| rd_vec | output | NRD | Vector flags at the selected positions |
| rd_state | output | NRD*2 | Speculation states at the selected positions |
| chk_valid | input | 1 | A non-speculable sink consumes an entry this cycle |
| chk_idx | input | IDX_W | Position consumed by the sink |
| fault_valid | output | 1 | Registered fault: the consumed entry was NaR |
| fault_id | output | ID_W | Identifier recorded in the faulting NaR |

## Verification
Pushes issued in a cycle show up on the read ports straight after the next rising edge, with no further delay. The bench therefore drives each stimulus at a falling edge and waits for one rising edge. It then sweeps every position through both read ports, using short steps that all fall before the next falling edge. The fault output is also due one edge after the sink check is presented, and it is sampled in the same window. Expected entries come from a bench-side model, which is advanced only at the moment of that edge. Functional-unit results are computed from the model's pre-edge contents.

// File: rtl/belt_pkg.sv
package belt_pkg;

  parameter int DATA_W = 32;
  localparam int NBYTE = DATA_W / 8;

  typedef enum logic [1:0] {
    ST_NORM = 2'd0,
    ST_NAR  = 2'd1,
    ST_NONE = 2'd2
  } spec_t;

  typedef enum logic [1:0] {
    W8  = 2'd0,
    W16 = 2'd1,
    W32 = 2'd2,
    W64 = 2'd3
  } wid_t;

  typedef enum logic {
    OP_ADD  = 1'b0,
    OP_PASS = 1'b1
  } op_t;

  typedef struct packed {
    logic [DATA_W-1:0] data;
    wid_t              wid;
    logic              vec;
    spec_t             st;
  } entry_t;

  localparam entry_t NONE_ENTRY = '{data: '0, wid: W8, vec: 1'b0, st: ST_NONE};

  // Byte-sliced adder: the carry is cut at every lane boundary.
  // A scalar result is masked down to its own width.
  function automatic logic [DATA_W-1:0] lane_add(
    input logic [DATA_W-1:0] a,
    input logic [DATA_W-1:0] b,
    input wid_t              w,
    input logic              v
  );
    logic [DATA_W-1:0] s;
    logic              c;
    logic [8:0]        t;
    s = '0;
    c = 1'b0;
    for (int k = 0; k < NBYTE; k++) begin
      if (k != 0 && v && (w == W8 || (w == W16 && (k % 2) == 0))) c = 1'b0;
      t = {1'b0, a[k*8 +: 8]} + {1'b0, b[k*8 +: 8]} + {8'd0, c};
      s[k*8 +: 8] = t[7:0];
      c = t[8];
    end
    if (!v) begin
      if (w == W8)  s[DATA_W-1:8]  = '0;
      if (w == W16) s[DATA_W-1:16] = '0;
    end
    return s;
  endfunction

endpackage

// File: rtl/belt_rst_sync.sv
module belt_rst_sync (
  input  logic clk,
  input  logic rst_n,
  output logic rst_ns
);
  logic [1:0] sync_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) sync_q <= 2'b00;
    else        sync_q <= {sync_q[0], 1'b1};
  end

  assign rst_ns = sync_q[1];
endmodule

// File: rtl/belt_alu.sv
module belt_alu
  import belt_pkg::*;
(
  input  op_t    op,
  input  entry_t opa,
  input  entry_t opb,
  output entry_t res
);
  always_comb begin
    res = opa;
    if (op == OP_ADD) begin
      if (opa.st == ST_NONE || opb.st == ST_NONE) begin
        res = '{data: '0, wid: opa.wid, vec: opa.vec, st: ST_NONE};
      end else if (opa.st == ST_NAR) begin
        res = opa;
      end else if (opb.st == ST_NAR) begin
        res = '{data: opb.data, wid: opa.wid, vec: opa.vec, st: ST_NAR};
      end else begin
        res = '{data: lane_add(opa.data, opb.data, opa.wid, opa.vec),
                wid: opa.wid, vec: opa.vec, st: ST_NORM};
      end
    end
  end
endmodule

// File: rtl/belt_store.sv
module belt_store
  import belt_pkg::*;
#(
  parameter int DEPTH = 8,
  parameter int NSLOT = 3
) (
  input  logic                   clk,
  input  logic                   rst_ns,
  input  logic [NSLOT-1:0]       push_v,
  input  entry_t [NSLOT-1:0]     push_e,
  output entry_t [DEPTH-1:0]     belt_q
);
  localparam int CNT_W = $clog2(NSLOT + 1);

  logic [CNT_W-1:0]   cnt;
  entry_t [NSLOT-1:0] packed_list;
  entry_t [DEPTH-1:0] belt_d;
  logic               belt_en;

  // Compact the valid slots in slot order, then shift the old entries back by the count.
  always_comb begin
    cnt = '0;
    packed_list = '0;
    for (int s = 0; s < NSLOT; s++) begin
      if (push_v[s]) begin
        packed_list[cnt] = push_e[s];
        cnt = cnt + CNT_W'(1);
      end
    end
    for (int p = 0; p < DEPTH; p++) begin
      belt_d[p] = belt_q[p];
      for (int j = 1; j <= NSLOT; j++) begin
        if (cnt == CNT_W'(j)) begin
          if (p < j) belt_d[p] = packed_list[p % NSLOT];
          else       belt_d[p] = belt_q[(p >= j) ? (p - j) : 0];
        end
      end
    end
    belt_en = (cnt != '0);
  end

  always_ff @(posedge clk or negedge rst_ns) begin
    if (!rst_ns) begin
      for (int p = 0; p < DEPTH; p++) belt_q[p] <= NONE_ENTRY;
    end else if (belt_en) begin
      belt_q <= belt_d;
    end
  end
endmodule

// File: rtl/temporal_belt.sv
module temporal_belt
  import belt_pkg::*;
#(
  parameter int DEPTH = 8,
  parameter int NALU  = 2,
  parameter int NRD   = 2,
  parameter int ID_W  = 16,
  localparam int IDX_W = $clog2(DEPTH)
) (
  input  logic                    clk,
  input  logic                    rst_n,
  input  logic                    lit_valid,
  input  logic [DATA_W-1:0]       lit_data,
  input  logic [1:0]              lit_wid,
  input  logic                    lit_vec,
  input  logic [1:0]              lit_state,
  input  logic [NALU-1:0]         alu_valid,
  input  logic [NALU-1:0]         alu_op,
  input  logic [NALU*IDX_W-1:0]   alu_src_a,
  input  logic [NALU*IDX_W-1:0]   alu_src_b,
  input  logic [NRD*IDX_W-1:0]    rd_idx,
  output logic [NRD*DATA_W-1:0]   rd_data,
  output logic [NRD*2-1:0]        rd_wid,
  output logic [NRD-1:0]          rd_vec,
  output logic [NRD*2-1:0]        rd_state,
  input  logic                    chk_valid,
  input  logic [IDX_W-1:0]        chk_idx,
  output logic                    fault_valid,
  output logic [ID_W-1:0]         fault_id
);
  localparam int NSLOT = NALU + 1;

  logic               rst_ns;
  entry_t [DEPTH-1:0] belt_q;
  entry_t [NSLOT-1:0] push_e;
  logic [NSLOT-1:0]   push_v;

  belt_rst_sync u_rst (.clk(clk), .rst_n(rst_n), .rst_ns(rst_ns));

  // Slot 0: the literal, with its tag exactly as given.
  assign push_v[0] = lit_valid;
  assign push_e[0] = '{data: lit_data, wid: wid_t'(lit_wid), vec: lit_vec,
                       st: spec_t'(lit_state)};

  for (genvar u = 0; u < NALU; u++) begin : g_alu
    belt_alu u_alu (
      .op  (op_t'(alu_op[u])),
      .opa (belt_q[alu_src_a[u*IDX_W +: IDX_W]]),
      .opb (belt_q[alu_src_b[u*IDX_W +: IDX_W]]),
      .res (push_e[u+1])
    );
    assign push_v[u+1] = alu_valid[u];
  end

  belt_store #(.DEPTH(DEPTH), .NSLOT(NSLOT)) u_store (
    .clk    (clk),
    .rst_ns (rst_ns),
    .push_v (push_v),
    .push_e (push_e),
    .belt_q (belt_q)
  );

  for (genvar r = 0; r < NRD; r++) begin : g_rd
    entry_t sel;
    assign sel = belt_q[rd_idx[r*IDX_W +: IDX_W]];
    assign rd_data[r*DATA_W +: DATA_W] = sel.data;
    assign rd_wid[r*2 +: 2]            = sel.wid;
    assign rd_vec[r]                   = sel.vec;
    assign rd_state[r*2 +: 2]          = sel.st;
  end

  // Sink check: a NaR reaching a non-speculable consumer faults.
  entry_t           chk_e;
  logic             fault_d;
  logic [ID_W-1:0]  fid_d;
  logic [ID_W-1:0]  fid_q;
  logic             fv_q;

  always_comb begin
    chk_e   = belt_q[chk_idx];
    fault_d = chk_valid && (chk_e.st == ST_NAR);
    fid_d   = fault_d ? chk_e.data[ID_W-1:0] : '0;
  end

  always_ff @(posedge clk or negedge rst_ns) begin
    if (!rst_ns) begin
      fv_q  <= 1'b0;
      fid_q <= '0;
    end else begin
      fv_q  <= fault_d;
      fid_q <= fid_d;
    end
  end

  assign fault_valid = fv_q;
  assign fault_id    = fid_q;
endmodule

// File: rtl/temporal_belt_chk.sv
module temporal_belt_chk
  import belt_pkg::*;
#(
  parameter int DEPTH = 8,
  parameter int NALU  = 2,
  parameter int ID_W  = 16,
  localparam int IDX_W = $clog2(DEPTH)
) (
  input  logic               clk,
  input  logic               rst_ns,
  input  entry_t [DEPTH-1:0] belt_q,
  input  logic               lit_valid,
  input  logic [DATA_W-1:0]  lit_data,
  input  logic [1:0]         lit_wid,
  input  logic               lit_vec,
  input  logic [1:0]         lit_state,
  input  logic [NALU-1:0]    alu_valid,
  input  logic               chk_valid,
  input  logic [IDX_W-1:0]   chk_idx,
  input  logic               fault_valid,
  input  logic [ID_W-1:0]    fault_id
);
  // R2
  one_push_shift_chk: assert property (@(posedge clk) disable iff (!rst_ns)
    ($countones({alu_valid, lit_valid}) == 1) |=>
      (belt_q[1] == $past(belt_q[0])) && (belt_q[DEPTH-1] == $past(belt_q[DEPTH-2])));

  // R3
  idle_hold_chk: assert property (@(posedge clk) disable iff (!rst_ns)
    (!lit_valid && alu_valid == '0) |=> $stable(belt_q));

  // R12
  lit_front_chk: assert property (@(posedge clk) disable iff (!rst_ns)
    (lit_valid && alu_valid == '0) |=>
      (belt_q[0] == $past({lit_data, lit_wid, lit_vec, lit_state})));

  // R11
  fault_cause_chk: assert property (@(posedge clk) disable iff (!rst_ns)
    fault_valid |-> ($past(chk_valid) && $past(belt_q[chk_idx].st == ST_NAR)));

  // R11
  fault_id_chk: assert property (@(posedge clk) disable iff (!rst_ns)
    fault_valid |-> (fault_id == $past(belt_q[chk_idx].data[ID_W-1:0])));

  // R11
  no_fault_chk: assert property (@(posedge clk) disable iff (!rst_ns)
    (chk_valid && belt_q[chk_idx].st != ST_NAR) |=> !fault_valid);
endmodule

bind temporal_belt temporal_belt_chk #(.DEPTH(DEPTH), .NALU(NALU), .ID_W(ID_W)) u_chk (
  .clk(clk), .rst_ns(rst_ns), .belt_q(belt_q), .lit_valid(lit_valid),
  .lit_data(lit_data), .lit_wid(lit_wid), .lit_vec(lit_vec), .lit_state(lit_state),
  .alu_valid(alu_valid), .chk_valid(chk_valid), .chk_idx(chk_idx),
  .fault_valid(fault_valid), .fault_id(fault_id)
);

// File: tb/temporal_belt_bench.sv
`timescale 1ns/1ps
module temporal_belt_bench;
  localparam int DEPTH = 8, NALU = 2, NRD = 2, ID_W = 16, IDX_W = 3, DW = 32;

  logic clk = 1'b0;
  logic rst_n;
  logic lit_valid; logic [DW-1:0] lit_data; logic [1:0] lit_wid; logic lit_vec; logic [1:0] lit_state;
  logic [NALU-1:0] alu_valid, alu_op;
  logic [NALU*IDX_W-1:0] alu_src_a, alu_src_b;
  logic [NRD*IDX_W-1:0] rd_idx;
  logic [NRD*DW-1:0] rd_data; logic [NRD*2-1:0] rd_wid; logic [NRD-1:0] rd_vec; logic [NRD*2-1:0] rd_state;
  logic chk_valid; logic [IDX_W-1:0] chk_idx;
  logic fault_valid; logic [ID_W-1:0] fault_id;

  int checks = 0, failures = 0;
  bit done = 0;
  logic [36:0] m [DEPTH];   // {data[36:5], wid[4:3], vec[2], st[1:0]}

  always #10 clk = ~clk;

  temporal_belt u_temporal_belt (.*);

  function automatic logic [36:0] mk(input logic [31:0] d, input logic [1:0] w,
                                     input logic v, input logic [1:0] s);
    return {d, w, v, s};
  endfunction

  function automatic logic [31:0] addm(input logic [31:0] a, input logic [31:0] b,
                                       input logic [1:0] w, input logic v);
    int L; logic [31:0] msk; logic [31:0] r; logic [31:0] x;
    L = (w == 2'd0) ? 8 : (w == 2'd1) ? 16 : 32;
    msk = (L == 32) ? 32'hFFFF_FFFF : ((32'd1 << L) - 32'd1);
    r = 32'd0;
    if (!v) r = (a + b) & msk;
    else for (int lo = 0; lo < 32; lo += L) begin
      x = ((a >> lo) + (b >> lo)) & msk;
      r = r | (x << lo);
    end
    return r;
  endfunction

  function automatic logic [36:0] f_alu(input logic op, input logic [36:0] a, input logic [36:0] b);
    if (op) return a;
    if (a[1:0] == 2'd2 || b[1:0] == 2'd2) return mk(32'd0, a[4:3], a[2], 2'd2);
    if (a[1:0] == 2'd1) return a;
    if (b[1:0] == 2'd1) return mk(b[36:5], a[4:3], a[2], 2'd1);
    return mk(addm(a[36:5], b[36:5], a[4:3], a[2]), a[4:3], a[2], 2'd0);
  endfunction

  task automatic check(input bit ok, input string tag, input string what,
                       input logic [36:0] got, input logic [36:0] exp);
    checks++;
    if (!ok) begin
      failures++;
      $display("FAIL %s %s got=%h exp=%h", tag, what, got, exp);
    end
  endtask

  task automatic sweep(input string tag);
    logic [36:0] g0, g1;
    for (int i = 0; i < DEPTH/2; i++) begin
      rd_idx = {IDX_W'(i + DEPTH/2), IDX_W'(i)};
      #1;
      g0 = {rd_data[DW-1:0], rd_wid[1:0], rd_vec[0], rd_state[1:0]};
      g1 = {rd_data[2*DW-1:DW], rd_wid[3:2], rd_vec[1], rd_state[3:2]};
      check(g0 === m[i], tag, $sformatf("pos %0d", i), g0, m[i]);
      check(g1 === m[i+DEPTH/2], tag, $sformatf("pos %0d", i + DEPTH/2), g1, m[i+DEPTH/2]);
    end
  endtask

  task automatic idle();
    lit_valid = 0; alu_valid = '0; chk_valid = 0;
  endtask

  // Inputs are already set (at a falling edge): predict, take the edge, compare.
  task automatic apply(input string tag);
    logic [36:0] lst [3]; logic [36:0] nm [DEPTH];
    int k; logic efv; logic [15:0] eid;
    k = 0;
    if (lit_valid) begin lst[k] = mk(lit_data, lit_wid, lit_vec, lit_state); k++; end
    for (int s = 0; s < NALU; s++)
      if (alu_valid[s]) begin
        lst[k] = f_alu(alu_op[s], m[alu_src_a[s*IDX_W +: IDX_W]], m[alu_src_b[s*IDX_W +: IDX_W]]);
        k++;
      end
    for (int p = 0; p < DEPTH; p++) nm[p] = (p < k) ? lst[p] : m[p-k];
    efv = chk_valid && (m[chk_idx][1:0] == 2'd1);
    eid = efv ? m[chk_idx][20:5] : 16'd0;
    @(posedge clk); #2;
    check({fault_valid, fault_id} === {efv, eid}, "R11", "fault",
          37'({fault_valid, fault_id}), 37'({efv, eid}));
    for (int p = 0; p < DEPTH; p++) m[p] = nm[p];
    sweep(tag);
  endtask

  task automatic lit(input logic [31:0] d, input logic [1:0] w, input logic v,
                     input logic [1:0] s, input string tag);
    @(negedge clk); idle();
    lit_valid = 1; lit_data = d; lit_wid = w; lit_vec = v; lit_state = s;
    apply(tag);
  endtask

  task automatic op1(input logic op, input int a, input int b, input string tag);
    @(negedge clk); idle();
    alu_valid = 2'b01; alu_op = {1'b0, op};
    alu_src_a = {3'd0, IDX_W'(a)}; alu_src_b = {3'd0, IDX_W'(b)};
    apply(tag);
  endtask

  task automatic chk(input int idx, input string tag);
    @(negedge clk); idle(); chk_valid = 1; chk_idx = IDX_W'(idx);
    apply(tag);
  endtask

  initial begin
    #(20 * 150000);
    if (!done) begin
      checks++; failures++;
      $display("FAIL watchdog got=hang exp=finish");
      $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
      $finish;
    end
  end

  initial begin
    void'($urandom(32'd20240611));
    rst_n = 0; idle(); lit_data = '0; lit_wid = '0; lit_vec = 0; lit_state = '0;
    alu_op = '0; alu_src_a = '0; alu_src_b = '0; rd_idx = '0; chk_idx = '0;
    for (int p = 0; p < DEPTH; p++) m[p] = mk(32'd0, 2'd0, 1'b0, 2'd2);
    repeat (3) @(posedge clk);
    #2; sweep("R1");
    check(fault_valid === 1'b0, "R1", "fault in reset", 37'(fault_valid), 37'd0);
    @(negedge clk); rst_n = 1;
    repeat (3) @(posedge clk);
    #2; sweep("R1");

    // R12 / R2: fill past the depth so the oldest drop off
    for (int i = 0; i < DEPTH + 2; i++) lit(32'h100 + 32'(i), 2'd2, 1'b0, 2'd0, "R2 R12");
    // R6: 8-bit scalar wrap, 16-bit scalar
    lit(32'h0000_01FF, 2'd0, 1'b0, 2'd0, "R12");
    lit(32'h0000_0001, 2'd0, 1'b0, 2'd0, "R12");
    op1(1'b0, 0, 1, "R6");
    lit(32'h0001_FFFF, 2'd1, 1'b0, 2'd0, "R12");
    op1(1'b0, 0, 0, "R6");
    // R7: lane-wise 8 and 16 bit
    lit(32'h01FF_00FF, 2'd0, 1'b1, 2'd0, "R12");
    lit(32'h0101_0101, 2'd0, 1'b0, 2'd0, "R12");
    op1(1'b0, 1, 0, "R7");
    lit(32'hFFFF_8000, 2'd1, 1'b1, 2'd0, "R12");
    op1(1'b0, 0, 0, "R7");
    // R9 / R11: NaR keeps its id, faults only at the sink
    lit(32'h0000_1234, 2'd2, 1'b0, 2'd1, "R12 R5");
    op1(1'b0, 1, 0, "R9");
    op1(1'b0, 0, 1, "R9");
    op1(1'b1, 0, 3, "R8");
    chk(0, "R11");
    chk(5, "R11");
    // R10: None dominates NaR
    lit(32'h0, 2'd2, 1'b0, 2'd2, "R12");
    op1(1'b0, 0, 1, "R10");
    chk(0, "R11");
    // R3: three pushes in one cycle, and a gap in the slots
    @(negedge clk); idle();
    lit_valid = 1; lit_data = 32'hAAAA; lit_wid = 2'd2; lit_vec = 0; lit_state = 2'd0;
    alu_valid = 2'b11; alu_op = 2'b11; alu_src_a = {3'd4, 3'd2}; alu_src_b = '0;
    apply("R3 R4");
    @(negedge clk); idle(); alu_valid = 2'b10; alu_op = 2'b00; alu_src_a = {3'd0, 3'd7}; alu_src_b = {3'd1, 3'd0};
    apply("R3 R4");
    @(negedge clk); idle(); apply("R3");

    // Random mix
    for (int n = 0; n < 400; n++) begin
      @(negedge clk); idle();
      lit_valid = 1'($urandom % 2);
      lit_data = $urandom; lit_wid = 2'($urandom % 4); lit_vec = 1'($urandom % 2);
      case ($urandom % 8) 0: lit_state = 2'd1; 1: lit_state = 2'd2; default: lit_state = 2'd0; endcase
      alu_valid = 2'($urandom % 4); alu_op = 2'($urandom % 4);
      alu_src_a = 6'($urandom); alu_src_b = 6'($urandom);
      chk_valid = 1'($urandom % 2); chk_idx = 3'($urandom);
      apply("R2 R3 R6 R7 R9 R10");
    end

    done = 1;
    $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end
endmodule